// File: doc/BRIEF.md
# I2C Master Clock Generator with Stretch-Aware Timing

This block produces the SCL clock of an I2C master on an open-drain line. It never drives the line high. It either pulls SCL low or lets it go, and it watches the real line level through an already-synchronized input. One down-counter, loaded from a 7-bit reload input, times both the low phase and the high phase. All timing advances only on a one-clock time-base tick (one machine cycle), so the phase lengths are measured in ticks.

After the low phase ends, the block releases SCL and freezes its counter. A slave that stretches the clock keeps the line low during this time. The high phase begins only on the first tick that sees the line high. At that tick the counter is reloaded, so every high phase lasts one full count no matter how long the line was held. If the line drops during a high phase, the block gives up that phase at once and times a full low phase. This covers another master pulling SCL low, for clock synchronization or arbitration.

Two one-clock strobes mark the points where SCL goes low and where it is first seen high. The shift, SDA and acknowledge logic uses them. All ports are plain control and status pins. No data stream crosses the block edge, so there is no handshake.

Top module: `i2c_scl_gen`

## Requirements
- R1: While rst_n is low, scl_drive_low, scl_rise and scl_fall are all 0, and any phase in progress is abandoned.
- R2: On the first tick with enable high after an idle period, the block drives SCL low and pulses scl_fall. A low phase lasts reload+1 ticks. Then SCL is released.
- R3: After the release, the counter holds and scl_rise stays 0 while scl_in reads 0. On the first tick that sees scl_in at 1, scl_rise pulses. With an undelayed line, fall to rise is reload+2 ticks.
- R4: A high phase lasts reload+1 ticks from scl_rise to the next scl_fall. This holds even after the line was stretched for any length of time.
- R5: At the end of a high phase the block drives SCL low, pulses scl_fall and starts a new low phase. scl_drive_low is 1 whenever scl_fall is 1.
- R6: If scl_in reads 0 on a tick during a high phase, the block drives SCL low and pulses scl_fall on that tick. It then times a full low phase of reload+1 ticks.
- R7: While enable is 0, SCL is released and no strobe is produced. Timing restarts per R2 when enable returns.
- R8: State changes only on a tick. Each strobe is one clock wide, and scl_rise and scl_fall are never 1 in the same cycle.
- R9: The reload value is captured when a phase starts. A change during a phase affects only later phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when high |
| tick | input | 1 | One-clock machine-cycle time-base pulse |
| reload | input | 7 | Phase length minus one, in ticks |
| scl_in | input | 1 | Synchronized SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | One-clock pulse when SCL is first seen high |
| scl_fall | output | 1 | One-clock pulse when SCL is pulled low |

## Verification
The bench sweeps every reload value from 0 to 127 on an undelayed line. For each value it checks the exact fall-to-rise and rise-to-fall spacings, which separates the extra sampling tick of the low side from the pure count of the high side. A stretched line held for many ticks shows that the counter freezes: the high phase that follows is still exactly one count. A second master pulling the line low mid-high checks the early abort, which is told apart from a normal rollover by timing. A reload change during a phase, enable dropped and restored, and a reset during a low phase check that the value is captured per phase and that the block goes quiet.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_baud_counter.sv
module scl_baud_counter #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic                run,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire
);
  localparam logic [RELOAD_W-1:0] ZERO = '0;
  localparam logic [RELOAD_W-1:0] ONE  = {{(RELOAD_W-1){1'b0}}, 1'b1};

  logic [RELOAD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (load) begin
      cnt_q <= reload;
    end else if (tick && run && cnt_q != ZERO) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expire = tick && run && (cnt_q == ZERO);

  AST_FROZEN_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q)) else $error("counter moved while held"); // R3
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic scl_in,
  input  logic expire,
  output logic run,
  output logic load,
  output logic rise_ev,
  output logic fall_ev,
  output logic drive_low
);
  scl_phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    rise_ev = 1'b0;
    fall_ev = 1'b0;
    if (!enable) begin
      state_d = PH_IDLE;
    end else if (tick) begin
      unique case (state_q)
        PH_IDLE: begin
          state_d = PH_LOW;
          load    = 1'b1;
          fall_ev = 1'b1;
        end
        PH_LOW: begin
          if (expire) state_d = PH_WAIT;
        end
        PH_WAIT: begin
          if (scl_in) begin
            state_d = PH_HIGH;
            load    = 1'b1;
            rise_ev = 1'b1;
          end
        end
        PH_HIGH: begin
          if (!scl_in || expire) begin
            state_d = PH_LOW;
            load    = 1'b1;
            fall_ev = 1'b1;
          end
        end
        default: state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign run       = (state_q == PH_LOW) || (state_q == PH_HIGH);
  assign drive_low = (state_q == PH_LOW);

  AST_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(state_q)) else $error("state moved off tick"); // R8
  AST_WAIT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WAIT) |-> !drive_low) else $error("drove low while waiting"); // R3
  AST_HIGH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && state_q == PH_HIGH && !scl_in) |=> drive_low) else $error("no abort"); // R6
endmodule

// File: rtl/scl_strobe_stage.sv
module scl_strobe_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic fall_ev,
  output logic rise_q,
  output logic fall_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_ev;
      fall_q <= fall_ev;
    end
  end

  AST_ONE_CLOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q) else $error("rise strobe too wide"); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q)) else $error("both strobes"); // R8
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                scl_in,
  output logic                scl_drive_low,
  output logic                scl_rise,
  output logic                scl_fall
);
  logic run, load, expire, rise_ev, fall_ev;

  scl_baud_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .run(run),
    .reload(reload), .expire(expire)
  );

  scl_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .scl_in(scl_in),
    .expire(expire), .run(run), .load(load), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .drive_low(scl_drive_low)
  );

  scl_strobe_stage u_stb (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rise_q(scl_rise), .fall_q(scl_fall)
  );

  AST_FALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> scl_drive_low) else $error("fall without drive"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_rise && !scl_fall && !scl_drive_low)) else $error("active while off"); // R7
  AST_RISE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> ($past(scl_in) && $past(tick))) else $error("rise without high line"); // R3
endmodule

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;
  localparam int TP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tick = 1'b0;
  logic [6:0] reload = 7'd0;
  logic slave_hold = 1'b0;
  logic other_pull = 1'b0;
  logic scl_in;
  logic scl_drive_low, scl_rise, scl_fall;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int t_rise = 0;
  int t_fall = 0;
  int tdiv = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign scl_in = !(scl_drive_low || slave_hold || other_pull);

  i2c_scl_gen u_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .reload(reload),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TP;
    tick <= (tdiv == 0);
    if (scl_rise) begin rise_cnt++; t_rise = cyc; end
    if (scl_fall) begin fall_cnt++; t_fall = cyc; end
    if (scl_rise && scl_fall) begin
      bad++;
      $display("FAIL R8 both strobes: actual=11 expected=not both");
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int c0 = rise_cnt;
    while (rise_cnt == c0) @(negedge clk);
  endtask

  task automatic wait_fall();
    int c0 = fall_cnt;
    while (fall_cnt == c0) @(negedge clk);
  endtask

  initial begin
    int f0, r0, c0, rc0, fc0, en_t;
    bit quiet;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 drive", int'(scl_drive_low), 0);
    chk("R1 strobes", int'(scl_rise) + int'(scl_fall), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: exhaustive reload sweep
    for (int n = 0; n < 128; n++) begin
      reload = 7'(n);
      enable = 1'b1;
      wait_fall();
      f0 = t_fall;
      chk("R5 drive at fall", int'(scl_drive_low), 1);
      wait_rise();
      r0 = t_rise;
      chk("R2/R3 low span", r0 - f0, (n + 2) * TP);
      chk("R3 released at rise", int'(scl_drive_low), 0);
      wait_fall();
      chk("R4 high span", t_fall - r0, (n + 1) * TP);
      enable = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R7: enable low keeps block quiet, restart on first tick
    reload = 7'd2;
    enable = 1'b1;
    wait_fall();
    repeat (2) @(negedge clk);
    enable = 1'b0;
    rc0 = rise_cnt; fc0 = fall_cnt; quiet = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (scl_drive_low) quiet = 1'b0;
    end
    chk("R7 quiet drive", int'(quiet), 1);
    chk("R7 no strobes", (rise_cnt - rc0) + (fall_cnt - fc0), 0);
    en_t = cyc;
    enable = 1'b1;
    wait_fall();
    chk("R7 restart within one tick", int'((t_fall - en_t) >= 1 && (t_fall - en_t) <= TP), 1);

    // R9: reload change mid low phase
    reload = 7'd4;
    enable = 1'b0; repeat (3) @(negedge clk);
    enable = 1'b1;
    wait_fall();
    f0 = t_fall;
    reload = 7'd10;
    wait_rise();
    chk("R9 low phase keeps old value", t_rise - f0, (4 + 2) * TP);
    r0 = t_rise;
    wait_fall();
    chk("R9 next phase uses new value", t_fall - r0, (10 + 1) * TP);

    // R3 R4: slave stretches clock
    reload = 7'd3;
    wait_fall();
    slave_hold = 1'b1;
    rc0 = rise_cnt;
    repeat (120) @(negedge clk);
    chk("R3 no rise while held", rise_cnt - rc0, 0);
    chk("R3 released while held", int'(scl_drive_low), 0);
    c0 = cyc;
    slave_hold = 1'b0;
    wait_rise();
    chk("R3 rise on first high tick", int'((t_rise - c0) >= 1 && (t_rise - c0) <= TP), 1);
    r0 = t_rise;
    wait_fall();
    chk("R4 high after stretch", t_fall - r0, (3 + 1) * TP);

    // R6: other master pulls low mid high
    reload = 7'd5;
    wait_rise();
    r0 = t_rise;
    repeat (2 * TP) @(negedge clk);
    other_pull = 1'b1;
    wait_fall();
    other_pull = 1'b0;
    chk("R6 early abort", int'((t_fall - r0) > 2 * TP && (t_fall - r0) <= 3 * TP), 1);
    chk("R6 drive after abort", int'(scl_drive_low), 1);
    f0 = t_fall;
    wait_rise();
    chk("R6 full low after abort", t_rise - f0, (5 + 2) * TP);

    // R1: reset during low phase
    wait_fall();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset aborts", int'(scl_drive_low), 0);
    @(negedge clk);
    chk("R1 no strobes in reset", int'(scl_rise) + int'(scl_fall), 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule